// File: doc/BRIEF.md
# Doorbell-Write Interrupt Collector

This block sits beside a root port and watches memory writes that arrive from downstream devices. When a full-word write lands on a doorbell address that software has programmed, the write's data value is taken as a vector number. The matching bit in a 32-vector status register is set if that vector is enabled. The pending vectors are combined into one level-sensitive interrupt line for the host.

Software programs the block through a small 32-bit register port. The 64-bit doorbell address is written as two halves. There are three vector registers: enable, mask and status. Software acknowledges vectors by writing ones to the status register. The interrupt line is raised when a doorbell write leaves an unmasked vector pending. It falls only when software has cleared every status bit, whether those bits are masked or not.

The snoop port reports, in the same cycle, whether a presented write was claimed by the doorbell window. Reads, and any write that is not claimed, are meant to continue on their normal path.

Top module: `msi_doorbell_irq`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The register offsets are: address low 0x820, address high 0x824, enable 0x828, mask 0x82C, status 0x830. Register reads are combinational on `reg_addr`.
- R2: A claimed doorbell write with data N (N below 32) sets status bit N on the next clock edge, but only when enable bit N is one. Otherwise the status register is unchanged.
- R3: After a claimed doorbell write, `irq` is one if (status AND NOT mask) is non-zero. A claimed write that leaves only masked bits pending does not raise `irq`. A change of the mask alone never changes `irq`.
- R4: Writing the status register clears each status bit written as one. `irq` falls only once the whole status register is zero. Masked bits that are still pending keep `irq` high.
- R5: A snoop write whose byte enables are not all four ones (`snp_be` not equal to 4'hF) is not claimed and changes no state.
- R6: The window claims writes only while the enable register is non-zero. A new address or enable value takes effect for snoop writes from the cycle after the register write.
- R7: A snoop read (`snp_write` = 0) to the doorbell address is never claimed and changes no state.
- R8: Writing the low or the high address register replaces only that 32-bit half of the 64-bit doorbell address.
- R9: A claimed doorbell write whose data is 32 or more sets no status bit. `snp_hit` still reports it as claimed.
- R10: When a doorbell write sets a bit and a status write clears the same bit in the same cycle, the bit ends up set.
- R11: `snp_hit` is one in the cycle a write is presented only when it is valid, a write, full-width, aimed at the exact doorbell address, and the enable register is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| snp_valid | input | 1 | Snooped transaction present |
| snp_write | input | 1 | One for write, zero for read |
| snp_be | input | 4 | Byte enables of the snooped access |
| snp_addr | input | 64 | Snooped address |
| snp_data | input | 32 | Snooped write data |
| snp_hit | output | 1 | Write claimed by the doorbell window |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions assume that each register write and each snoop transaction is held for exactly one clock. They also assume that inputs are stable around the sampling edge and that the enable register never holds bits above the vector count. The stimulus changes every input only on the falling edge and pulses each strobe for a single cycle. It keeps every vector number either within the 32 vectors or deliberately out of range, to exercise R9. It checks `snp_hit` half a cycle after it drives a transaction, and checks register state only after the following rising edge.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned OFF_W  = 12;

    localparam logic [OFF_W-1:0] OFF_ADDR_LO = 12'h820;
    localparam logic [OFF_W-1:0] OFF_ADDR_HI = 12'h824;
    localparam logic [OFF_W-1:0] OFF_ENABLE  = 12'h828;
    localparam logic [OFF_W-1:0] OFF_MASK    = 12'h82C;
    localparam logic [OFF_W-1:0] OFF_STATUS  = 12'h830;

    typedef struct packed {
        logic [63:0]      base;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] mask;
    } cfg_t;

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic             irq;
    } vec_state_t;
endpackage

// File: rtl/msi_db_cfg.sv
module msi_db_cfg
    import msi_db_pkg::*;
#(
    parameter int unsigned NVEC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [OFF_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output cfg_t             cfg
);
    localparam logic [REG_W-1:0] VEC_MASK = {REG_W{1'b1}} >> (REG_W - NVEC);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            unique case (reg_addr)
                OFF_ADDR_LO: cfg_d.base[31:0]  = reg_wdata;
                OFF_ADDR_HI: cfg_d.base[63:32] = reg_wdata;
                OFF_ENABLE:  cfg_d.en          = reg_wdata & VEC_MASK;
                OFF_MASK:    cfg_d.mask        = reg_wdata & VEC_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R8: a low-half write leaves the upper half alone, and the reverse
    a_r8_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_ADDR_LO) |=> (cfg_q.base[63:32] == $past(cfg_q.base[63:32])));
    a_r8_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_ADDR_HI) |=> (cfg_q.base[31:0] == $past(cfg_q.base[31:0])));
endmodule

// File: rtl/msi_db_match.sv
module msi_db_match
    import msi_db_pkg::*;
#(
    parameter int unsigned NVEC = 32
) (
    input  logic             snp_valid,
    input  logic             snp_write,
    input  logic [3:0]       snp_be,
    input  logic [63:0]      snp_addr,
    input  logic [REG_W-1:0] snp_data,
    input  cfg_t             cfg,
    output logic             hit,
    output logic [REG_W-1:0] set_vec
);
    localparam logic [REG_W-1:0] VEC_MASK = {REG_W{1'b1}} >> (REG_W - NVEC);

    logic window_open;
    logic in_range;

    always_comb begin
        window_open = |cfg.en;
        hit         = snp_valid && snp_write && (&snp_be)
                      && (snp_addr == cfg.base) && window_open;
        in_range    = (snp_data < REG_W'(NVEC));
        set_vec     = '0;
        if (hit && in_range)
            set_vec = (REG_W'(1) << snp_data[4:0]) & cfg.en & VEC_MASK;
    end

    // R7: a read is never claimed
    always_comb begin
        a_r7_read_not_claimed: assert (!(snp_valid && !snp_write && hit));
    end
    // R2: only enabled vectors may be set
    always_comb begin
        a_r2_set_within_enable: assert ((set_vec & ~cfg.en) == '0);
    end
endmodule

// File: rtl/msi_db_vec.sv
module msi_db_vec
    import msi_db_pkg::*;
#(
    parameter int unsigned NVEC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [REG_W-1:0] set_vec,
    input  logic             clr_wr,
    input  logic [REG_W-1:0] clr_bits,
    input  logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] status,
    output logic             irq
);
    localparam logic [REG_W-1:0] VEC_MASK = {REG_W{1'b1}} >> (REG_W - NVEC);

    vec_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.status = ((st_q.status & ~(clr_wr ? clr_bits : '0)) | set_vec) & VEC_MASK;
        if (hit && ((st_d.status & ~mask) != '0))
            st_d.irq = 1'b1;
        else if (clr_wr && (st_d.status == '0))
            st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign irq    = st_q.irq;

    // R2: newly set bits come only from the decoder's set vector
    a_r2_bits_from_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.status & ~$past(st_q.status) & ~$past(set_vec)) == '0));
    // R3: the line rises only after a claimed doorbell write
    a_r3_rise_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(hit));
    // R4: the line falls only with an empty status register
    a_r4_fall_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.irq) |-> (st_q.status == '0));
    // R4: without a status write the line holds high, masked or not
    a_r4_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !clr_wr) |=> st_q.irq);
    // R10: a bit being set ends set even under a same-cycle clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((st_q.status & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/msi_doorbell_irq.sv
module msi_doorbell_irq
    import msi_db_pkg::*;
#(
    parameter int unsigned NVEC = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        snp_valid,
    input  logic        snp_write,
    input  logic [3:0]  snp_be,
    input  logic [63:0] snp_addr,
    input  logic [31:0] snp_data,
    output logic        snp_hit,
    output logic        irq
);
    cfg_t             cfg;
    logic             hit;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] status;
    logic             clr_wr;

    assign clr_wr = reg_wr && (reg_addr == OFF_STATUS);

    msi_db_cfg #(.NVEC(NVEC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg(cfg)
    );

    msi_db_match #(.NVEC(NVEC)) u_match (
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_be(snp_be),
        .snp_addr(snp_addr), .snp_data(snp_data), .cfg(cfg),
        .hit(hit), .set_vec(set_vec)
    );

    msi_db_vec #(.NVEC(NVEC)) u_vec (
        .clk(clk), .rst_n(rst_n), .hit(hit), .set_vec(set_vec),
        .clr_wr(clr_wr), .clr_bits(reg_wdata), .mask(cfg.mask),
        .status(status), .irq(irq)
    );

    always_comb begin
        unique case (reg_addr)
            OFF_ADDR_LO: reg_rdata = cfg.base[31:0];
            OFF_ADDR_HI: reg_rdata = cfg.base[63:32];
            OFF_ENABLE:  reg_rdata = cfg.en;
            OFF_MASK:    reg_rdata = cfg.mask;
            OFF_STATUS:  reg_rdata = status;
            default:     reg_rdata = '0;
        endcase
    end

    assign snp_hit = hit;

    // R6: nothing is claimed while every vector is disabled
    a_r6_closed_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en == '0) |-> !snp_hit);
    // R5: partial-width writes are never claimed
    a_r5_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_be != 4'hF) |-> !snp_hit);
endmodule

// File: tb/tb_msi_doorbell_irq.sv
module tb_msi_doorbell_irq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        snp_valid = 1'b0;
    logic        snp_write = 1'b0;
    logic [3:0]  snp_be = '0;
    logic [63:0] snp_addr = '0;
    logic [31:0] snp_data = '0;
    logic        snp_hit;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_doorbell_irq dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snp_valid(snp_valid),
        .snp_write(snp_write), .snp_be(snp_be), .snp_addr(snp_addr),
        .snp_data(snp_data), .snp_hit(snp_hit), .irq(irq)
    );

    typedef struct {
        string       tag;
        int          kind;   // 0 irq, 1 reg_rdata, 2 snp_hit
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference state, kept from the requirements
    logic [63:0] m_base = '0;
    logic [31:0] m_en = '0, m_mask = '0, m_stat = '0;
    logic        m_irq = 1'b0;

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (q.size() > 0);
            it = q.pop_front();
            case (it.kind)
                0:       act = {31'b0, irq};
                1:       act = reg_rdata;
                default: act = {31'b0, snp_hit};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(string tag, int kind, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp;
        q.push_back(it);
        #1;
    endtask

    task automatic model_reg(logic [11:0] a, logic [31:0] d);
        case (a)
            12'h820: m_base[31:0]  = d;
            12'h824: m_base[63:32] = d;
            12'h828: m_en   = d;
            12'h82C: m_mask = d;
            default: ;
        endcase
    endtask

    // performs one register write and optionally a snoop in the same cycle
    task automatic cycle(bit do_reg, logic [11:0] a, logic [31:0] d,
                         bit do_snp, bit wr, logic [3:0] be, logic [63:0] sa,
                         logic [31:0] sd, string tag);
        bit hit_m;
        logic [31:0] set_m, clr_m;
        @(negedge clk);
        reg_wr = do_reg; reg_addr = a; reg_wdata = d;
        snp_valid = do_snp; snp_write = wr; snp_be = be; snp_addr = sa; snp_data = sd;
        hit_m = do_snp && wr && be == 4'hF && sa == m_base && m_en != 0;
        #1;
        if (do_snp) push(tag, 2, {31'b0, hit_m});
        set_m = (hit_m && sd < 32) ? ((32'd1 << sd[4:0]) & m_en) : 32'd0;
        clr_m = (do_reg && a == 12'h830) ? d : 32'd0;
        @(posedge clk);
        m_stat = (m_stat & ~clr_m) | set_m;
        if (hit_m && ((m_stat & ~m_mask) != 0)) m_irq = 1'b1;
        else if (do_reg && a == 12'h830 && m_stat == 0) m_irq = 1'b0;
        if (do_reg) model_reg(a, d);
        @(negedge clk);
        reg_wr = 1'b0; snp_valid = 1'b0;
    endtask

    task automatic wreg(logic [11:0] a, logic [31:0] d);
        cycle(1'b1, a, d, 1'b0, 1'b0, 4'h0, 64'h0, 32'h0, "");
    endtask

    task automatic snoop(bit wr, logic [3:0] be, logic [63:0] sa, logic [31:0] sd, string tag);
        cycle(1'b0, 12'h0, 32'h0, 1'b1, wr, be, sa, sd, tag);
    endtask

    task automatic chk_reg(logic [11:0] a, logic [31:0] e, string tag);
        reg_addr = a;
        #1;
        push(tag, 1, e);
    endtask

    task automatic chk_state(string tag);
        chk_reg(12'h830, m_stat, {tag, " status"});
        push({tag, " irq"}, 0, {31'b0, m_irq});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk_reg(12'h820, 0, "R1 addr lo");
        chk_reg(12'h824, 0, "R1 addr hi");
        chk_reg(12'h828, 0, "R1 enable");
        chk_reg(12'h82C, 0, "R1 mask");
        chk_state("R1 reset");
        // R6: window closed while enable is zero (base is 0)
        snoop(1'b1, 4'hF, 64'h0, 32'd0, "R6 disabled window");
        chk_state("R6 disabled");
        // R8: half writes
        wreg(12'h820, 32'h1000_0040);
        wreg(12'h824, 32'h0000_0001);
        chk_reg(12'h820, 32'h1000_0040, "R8 lo");
        chk_reg(12'h824, 32'h0000_0001, "R8 hi");
        wreg(12'h820, 32'h2000_0080);
        chk_reg(12'h824, 32'h0000_0001, "R8 hi kept");
        chk_reg(12'h820, 32'h2000_0080, "R8 lo replaced");
        // R2/R3/R11: enabled vector sets status and raises irq
        wreg(12'h828, 32'h0000_00FF);
        chk_reg(12'h828, 32'h0000_00FF, "R1 enable readback");
        snoop(1'b1, 4'hF, m_base, 32'd5, "R11 claimed write");
        chk_state("R2 R3 vector 5");
        snoop(1'b1, 4'hF, m_base, 32'd9, "R11 claimed disabled vector");
        chk_state("R2 disabled vector 9");
        snoop(1'b1, 4'hF, m_base, 32'd40, "R9 out of range claimed");
        chk_state("R9 out of range");
        snoop(1'b0, 4'hF, m_base, 32'd1, "R7 read not claimed");
        chk_state("R7 read");
        snoop(1'b1, 4'h3, m_base, 32'd1, "R5 partial not claimed");
        chk_state("R5 partial");
        snoop(1'b1, 4'hF, m_base + 64'd4, 32'd1, "R11 wrong address");
        chk_state("R11 wrong address");
        // R4: masked pending bit keeps irq high
        wreg(12'h82C, 32'h0000_0002);
        snoop(1'b1, 4'hF, m_base, 32'd1, "R3 masked claimed");
        chk_state("R3 masked vector 1");
        wreg(12'h830, 32'h0000_0020);
        chk_state("R4 partial clear");
        wreg(12'h830, 32'h0000_0002);
        chk_state("R4 full clear");
        // R3: masked-only doorbell does not raise; unmasking does not raise
        snoop(1'b1, 4'hF, m_base, 32'd1, "R3 masked only");
        chk_state("R3 masked only");
        wreg(12'h82C, 32'h0);
        chk_state("R3 unmask alone");
        wreg(12'h830, 32'hFFFF_FFFF);
        chk_state("R4 clear all");
        // R6: address move takes effect next cycle
        snoop(1'b1, 4'hF, 64'h0000_0001_2000_0080, 32'd2, "R6 old address");
        wreg(12'h820, 32'h3000_0000);
        snoop(1'b1, 4'hF, 64'h0000_0001_2000_0080, 32'd3, "R6 moved away");
        snoop(1'b1, 4'hF, 64'h0000_0001_3000_0000, 32'd4, "R6 new address");
        chk_state("R6 moved");
        wreg(12'h830, 32'hFFFF_FFFF);
        // R10: set and clear of the same bit in one cycle
        snoop(1'b1, 4'hF, m_base, 32'd3, "R10 first set");
        cycle(1'b1, 12'h830, 32'h0000_0008, 1'b1, 1'b1, 4'hF, m_base, 32'd3, "R10 same cycle");
        chk_state("R10 set wins");
        // R6: enable to zero closes the window
        wreg(12'h828, 32'h0);
        snoop(1'b1, 4'hF, m_base, 32'd3, "R6 closed again");
        chk_state("R6 closed");
        wait (q.size() == 0);
        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule